// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from one fast line, three external request lines and a parameterised group of on-chip peripheral lines, and turns them into two active-low processor request outputs: one for the fast path and one for normal interrupts. Every source carries a mask bit, a 3-bit priority, a sensitivity choice and a handler vector. The mask bits are changed through separate set and clear strobes, so that no read-modify-write is needed. Priority, sensitivity and vector are written one source at a time through a small configuration port.

When the processor fetches the normal vector, the controller returns the handler vector of the winning source. The winner is the highest-priority source that is pending and unmasked, with ties going to the lowest index. The fetch also makes that source's priority the current service level, by pushing it onto an eight-entry level stack. While a level is in service, only strictly higher priorities raise the normal request. An end-of-service strobe pops the stack. If nothing is eligible when the fetch arrives, a spurious vector comes back and the stack is left alone.

A debug protect input makes vector fetches free of side effects. In that mode a separate acknowledge strobe performs the push and the pending clear instead.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `nirq` and `nfiq` are 1, `mask_q` is all zero, `nest_depth` is 0 and `cur_lvl` is 0.
- R2: Mask bit i becomes 1 the cycle after `mask_set[i]` is pulsed and 0 the cycle after `mask_clr[i]` is pulsed. Clear wins when both are pulsed together. Other bits are unchanged. A masked source never requests.
- R3: Sources are numbered fiq_in = 0, ext_irq[k] = 1+k, per_irq[k] = 4+k. Among unmasked pending sources 1 and up, the winner has the numerically largest priority. Equal priorities go to the lowest number. `vec_data` shows the winner's vector whenever `nirq` is 0 and `fvec_rd` is 0.
- R4: Source 0 drives only `nfiq`, which is 0 exactly while source 0 is pending and unmasked. While `fvec_rd` is high, `vec_data` shows source 0's vector. Outside protect mode, `fvec_rd` clears source 0's latched edge.
- R5: A fetch or acknowledge made while `nirq` is 1 returns the spurious vector (parameter, default all ones) and leaves `nest_depth` unchanged.
- R6: A fetch (`vec_rd` with `prot_en` low) or `ack_wr` made while `nirq` is 0 raises `nest_depth` by one and sets `cur_lvl` to the winner's priority. Afterwards `nirq` is 0 only for priorities strictly above `cur_lvl`.
- R7: `eoi` with `nest_depth` > 0 lowers `nest_depth` by one and restores the previous level (0 when the stack empties). `eoi` with an empty stack has no effect. When a push and `eoi` occur in the same cycle, the push takes effect and the `eoi` is dropped.
- R8: A level-sensitive source (`cfg_edge` = 0) is pending exactly while its input is 1. An edge-sensitive source (`cfg_edge` = 1) becomes pending the cycle after a 0-to-1 input change. It stays pending until its vector is acknowledged, even if the input falls.
- R9: With `prot_en` high, `vec_rd` and `fvec_rd` return the same vector as without it but change neither `nest_depth` nor any pending state. `ack_wr` acknowledges regardless of `prot_en`.
- R10: `nest_depth` never exceeds 8. The stack can be filled to 8 by reprogramming one source's priority upward between fetches. A ninth fetch is spurious.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fiq_in | input | 1 | Fast interrupt request (source 0) |
| ext_irq | input | 3 | External request lines (sources 1..3) |
| per_irq | input | NPER | Peripheral request lines (sources 4..) |
| mask_set | input | NPER+4 | Per-source mask enable strobes |
| mask_clr | input | NPER+4 | Per-source mask disable strobes |
| cfg_we | input | 1 | Write one source's configuration |
| cfg_src | input | clog2(NPER+4) | Source index for the configuration write |
| cfg_prio | input | 3 | Priority to write (7 highest) |
| cfg_edge | input | 1 | 1 = edge sensitive, 0 = level sensitive |
| cfg_vec | input | VW | Handler vector to write |
| vec_rd | input | 1 | Normal vector fetch strobe |
| fvec_rd | input | 1 | Fast vector fetch strobe |
| prot_en | input | 1 | Protect mode: fetches have no side effects |
| ack_wr | input | 1 | Explicit acknowledge strobe |
| eoi | input | 1 | End-of-service strobe |
| vec_data | output | VW | Vector returned to the processor |
| nirq | output | 1 | Normal interrupt request, active low |
| nfiq | output | 1 | Fast interrupt request, active low |
| mask_q | output | NPER+4 | Current mask bits |
| cur_lvl | output | 3 | Level at the top of the stack |
| nest_depth | output | 4 | Number of stacked levels |

## Verification
The embedded properties check the following on every clock:
- the stack bound;
- that each accepted acknowledge adds one level, strictly above the one below it;
- that spurious fetches and protect-mode fetches leave the depth alone;
- that a non-empty stack pops on end of service;
- that cleared mask bits are really cleared;
- that a masked fast source never requests.

Which source wins a tie, what vector comes back, how edge latches behave across input drops, and whether a level source that vanished before the fetch yields the spurious vector can only be shown by the bench's scenarios. The bench compares every output, every cycle, against a reference model built from the requirements.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NPER = 4,
  parameter int VW = 16,
  parameter logic [VW-1:0] SPUR_VEC = {VW{1'b1}}
)(
  input  logic clk,
  input  logic rst_n,
  input  logic fiq_in,
  input  logic [2:0] ext_irq,
  input  logic [NPER-1:0] per_irq,
  input  logic [NPER+3:0] mask_set,
  input  logic [NPER+3:0] mask_clr,
  input  logic cfg_we,
  input  logic [$clog2(NPER+4)-1:0] cfg_src,
  input  logic [2:0] cfg_prio,
  input  logic cfg_edge,
  input  logic [VW-1:0] cfg_vec,
  input  logic vec_rd,
  input  logic fvec_rd,
  input  logic prot_en,
  input  logic ack_wr,
  input  logic eoi,
  output logic [VW-1:0] vec_data,
  output logic nirq,
  output logic nfiq,
  output logic [NPER+3:0] mask_q,
  output logic [2:0] cur_lvl,
  output logic [3:0] nest_depth
);
  localparam int NSRC = NPER + 4;
  localparam int SW = $clog2(NSRC);
  localparam int LVLS = 8;

  logic [NSRC-1:0] raw, prev_q, epend_q, edge_q, pend, act, clr;
  logic [2:0] prio_q [NSRC];
  logic [VW-1:0] vec_q [NSRC];
  logic [2:0] stk_q [LVLS];
  logic [3:0] depth_q;
  logic [2:0] top;
  logic win_ok, elig, take, ftake, push, pop;
  logic [SW-1:0] win_id;
  logic [2:0] win_p;

  assign raw   = {per_irq, ext_irq, fiq_in};
  assign pend  = (edge_q & epend_q) | (~edge_q & raw);
  assign act   = pend & mask_q;
  assign top   = 3'(depth_q - 4'd1);
  assign cur_lvl = (depth_q == 4'd0) ? 3'd0 : stk_q[top];
  assign nest_depth = depth_q;

  always_comb begin
    win_ok = 1'b0;
    win_id = '0;
    win_p  = 3'd0;
    for (int i = 1; i < NSRC; i++) begin
      if (act[i] && (!win_ok || prio_q[i] > win_p)) begin
        win_ok = 1'b1;
        win_id = SW'(i);
        win_p  = prio_q[i];
      end
    end
  end

  assign elig  = win_ok && (depth_q == 4'd0 || win_p > cur_lvl);
  assign nirq  = ~elig;
  assign nfiq  = ~act[0];
  assign take  = (vec_rd & ~prot_en) | ack_wr;
  assign ftake = fvec_rd & ~prot_en;
  assign push  = take & elig;
  assign pop   = eoi & ~push & (depth_q != 4'd0);

  assign vec_data = fvec_rd ? vec_q[0] : (elig ? vec_q[win_id] : SPUR_VEC);

  always_comb begin
    clr = '0;
    if (push) clr[win_id] = 1'b1;
    if (ftake) clr[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      epend_q <= '0;
      mask_q  <= '0;
      edge_q  <= '0;
      depth_q <= 4'd0;
      for (int i = 0; i < NSRC; i++) begin
        prio_q[i] <= 3'd0;
        vec_q[i]  <= '0;
      end
      for (int i = 0; i < LVLS; i++) stk_q[i] <= 3'd0;
    end else begin
      prev_q  <= raw;
      epend_q <= (epend_q & ~clr) | (raw & ~prev_q);
      mask_q  <= (mask_q | mask_set) & ~mask_clr;
      if (cfg_we) begin
        prio_q[cfg_src] <= cfg_prio;
        edge_q[cfg_src] <= cfg_edge;
        vec_q[cfg_src]  <= cfg_vec;
      end
      if (push) begin
        stk_q[depth_q[2:0]] <= win_p;
        depth_q <= depth_q + 4'd1;
      end else if (pop) begin
        depth_q <= depth_q - 4'd1;
      end
    end
  end

  a_r10_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    nest_depth <= 4'd8);

  a_r6_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !nirq) |=> nest_depth == $past(nest_depth) + 4'd1);

  a_r6_level_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !nirq && nest_depth != 4'd0) |=> cur_lvl > $past(cur_lvl));

  a_r5_spur_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    (take && nirq && !eoi) |=> $stable(nest_depth));

  a_r9_prot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && prot_en && !ack_wr && !eoi) |=> $stable(nest_depth));

  a_r7_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !(take && !nirq) && nest_depth != 4'd0) |=> nest_depth == $past(nest_depth) - 4'd1);

  a_r2_mask_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_clr != '0) |=> (mask_q & $past(mask_clr)) == '0);

  a_r4_fiq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q[0] |-> nfiq);
endmodule

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
  localparam int NPER = 4;
  localparam int VW = 16;
  localparam int NSRC = NPER + 4;
  localparam logic [VW-1:0] SPUR = 16'hFFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fiq_in = 0;
  logic [2:0] ext_irq = '0;
  logic [NPER-1:0] per_irq = '0;
  logic [NSRC-1:0] mask_set = '0, mask_clr = '0;
  logic cfg_we = 0, cfg_edge = 0;
  logic [2:0] cfg_src = '0, cfg_prio = '0;
  logic [VW-1:0] cfg_vec = '0;
  logic vec_rd = 0, fvec_rd = 0, prot_en = 0, ack_wr = 0, eoi = 0;
  logic [VW-1:0] vec_data;
  logic nirq, nfiq;
  logic [NSRC-1:0] mask_q;
  logic [2:0] cur_lvl;
  logic [3:0] nest_depth;

  int tests = 0, fails = 0;
  string tag = "R1";

  logic [NSRC-1:0] m_mask = '0, m_edge = '0, m_ep = '0, m_prev = '0;
  logic [2:0] m_prio [NSRC];
  logic [VW-1:0] m_vec [NSRC];
  logic [2:0] m_stk [8];
  int m_depth = 0;

  always #2 clk = ~clk;

  vec_irq_ctrl #(.NPER(NPER), .VW(VW), .SPUR_VEC(SPUR)) uut (
    .clk(clk), .rst_n(rst_n), .fiq_in(fiq_in), .ext_irq(ext_irq), .per_irq(per_irq),
    .mask_set(mask_set), .mask_clr(mask_clr), .cfg_we(cfg_we), .cfg_src(cfg_src),
    .cfg_prio(cfg_prio), .cfg_edge(cfg_edge), .cfg_vec(cfg_vec), .vec_rd(vec_rd),
    .fvec_rd(fvec_rd), .prot_en(prot_en), .ack_wr(ack_wr), .eoi(eoi),
    .vec_data(vec_data), .nirq(nirq), .nfiq(nfiq), .mask_q(mask_q),
    .cur_lvl(cur_lvl), .nest_depth(nest_depth));

  task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic logic [2:0] m_cur();
    return (m_depth == 0) ? 3'd0 : m_stk[m_depth-1];
  endfunction

  task automatic tick();
    logic [NSRC-1:0] raw, act, clr;
    logic ok, el, tk, ftk, ps;
    int wid;
    logic [2:0] wp;
    logic [VW-1:0] ev;
    @(negedge clk);
    raw = {per_irq, ext_irq, fiq_in};
    act = ((m_edge & m_ep) | (~m_edge & raw)) & m_mask;
    ok = 0; wid = 0; wp = 0;
    for (int i = 1; i < NSRC; i++)
      if (act[i] && (!ok || m_prio[i] > wp)) begin ok = 1; wid = i; wp = m_prio[i]; end
    el = ok && (m_depth == 0 || wp > m_cur());
    ev = fvec_rd ? m_vec[0] : (el ? m_vec[wid] : SPUR);
    chk("nirq", 32'(nirq), 32'(!el));
    chk("nfiq", 32'(nfiq), 32'(!act[0]));
    chk("mask_q", 32'(mask_q), 32'(m_mask));
    chk("nest_depth", 32'(nest_depth), 32'(m_depth));
    chk("cur_lvl", 32'(cur_lvl), 32'(m_cur()));
    if (vec_rd || fvec_rd || ack_wr) chk("vec_data", 32'(vec_data), 32'(ev));
    tk = (vec_rd & ~prot_en) | ack_wr;
    ftk = fvec_rd & ~prot_en;
    ps = tk & el;
    clr = '0;
    if (ps) clr[wid] = 1'b1;
    if (ftk) clr[0] = 1'b1;
    m_ep = (m_ep & ~clr) | (raw & ~m_prev);
    m_prev = raw;
    m_mask = (m_mask | mask_set) & ~mask_clr;
    if (cfg_we) begin
      m_prio[cfg_src] = cfg_prio; m_edge[cfg_src] = cfg_edge; m_vec[cfg_src] = cfg_vec;
    end
    if (ps) begin m_stk[m_depth] = wp; m_depth++; end
    else if (eoi && m_depth > 0) m_depth--;
    @(posedge clk); #1;
    cfg_we = 0; mask_set = '0; mask_clr = '0; vec_rd = 0; fvec_rd = 0; ack_wr = 0; eoi = 0;
  endtask

  task automatic cfg(int s, int p, bit e, logic [VW-1:0] v);
    cfg_we = 1; cfg_src = 3'(s); cfg_prio = 3'(p); cfg_edge = e; cfg_vec = v;
    tick();
  endtask

  task automatic drain();
    while (m_depth > 0) begin eoi = 1; tick(); end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < NSRC; i++) begin m_prio[i] = 0; m_vec[i] = 0; end
    for (int i = 0; i < 8; i++) m_stk[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tag = "R1"; tick(); tick();

    tag = "R2";
    for (int s = 0; s < NSRC; s++) cfg(s, s % 8, 1'b0, 16'h100 + 16'(s));
    ext_irq = 3'b100; tick();
    mask_set = 8'h08; tick(); tick();
    mask_set = 8'h0C; mask_clr = 8'h08; tick(); tick();
    mask_set = 8'hFE; tick();
    ext_irq = 0; tick();

    tag = "R3";
    cfg(2, 5, 0, 16'hA002); cfg(5, 5, 0, 16'hB005); cfg(1, 3, 0, 16'hC001);
    ext_irq = 3'b011; per_irq = 4'b0010; vec_rd = 1; prot_en = 1; tick();
    prot_en = 0; vec_rd = 1; tick();
    vec_rd = 1; tick();
    ext_irq = 0; per_irq = 0; drain();

    tag = "R8";
    cfg(4, 6, 1, 16'hE004);
    per_irq = 4'b0001; tick(); per_irq = 0; tick(); tick();
    vec_rd = 1; tick(); tick(); drain();

    tag = "R5";
    per_irq = 4'b0100; tick();
    per_irq = 0; vec_rd = 1; tick(); tick();

    tag = "R9";
    cfg(6, 4, 1, 16'h9006);
    per_irq = 4'b0100; tick(); per_irq = 0;
    prot_en = 1; vec_rd = 1; tick();
    vec_rd = 1; tick();
    ack_wr = 1; tick(); prot_en = 0; tick();

    tag = "R7";
    eoi = 1; tick(); eoi = 1; tick(); tick();

    tag = "R10";
    ext_irq = 3'b001;
    for (int p = 0; p < 8; p++) begin cfg(1, p, 0, 16'h7000 + 16'(p)); vec_rd = 1; tick(); end
    vec_rd = 1; tick();
    ext_irq = 0; drain();

    tag = "R4";
    cfg(0, 0, 1, 16'hF000); mask_set = 8'h01; tick();
    fiq_in = 1; tick(); fiq_in = 0; tick();
    prot_en = 1; fvec_rd = 1; tick(); prot_en = 0;
    fvec_rd = 1; tick(); tick();

    tag = "R6";
    for (int n = 0; n < 4000; n++) begin
      fiq_in = ($urandom % 6 == 0);
      ext_irq = 3'($urandom) & 3'($urandom);
      per_irq = 4'($urandom) & 4'($urandom);
      vec_rd = ($urandom % 4 == 0);
      fvec_rd = ($urandom % 10 == 0);
      ack_wr = ($urandom % 12 == 0);
      prot_en = ($urandom % 8 == 0);
      eoi = ($urandom % 5 == 0);
      if ($urandom % 9 == 0) mask_set = 8'($urandom);
      if ($urandom % 13 == 0) mask_clr = 8'($urandom);
      if ($urandom % 10 == 0) begin
        cfg_we = 1; cfg_src = 3'($urandom); cfg_prio = 3'($urandom);
        cfg_edge = 1'($urandom); cfg_vec = 16'($urandom);
      end
      tick();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule